// File: doc/BRIEF.md
# Daisy-Chain Auto-Addressing Node

This block is the link controller for one station in a chain of serial nodes. Each station has an upstream side, which faces the host, and a downstream side, which faces the stations further along. The byte receiver on the upstream side delivers bytes to this block. The block decodes them, takes its address during enumeration and drives two line selectors. The forward selector decides whether the upstream receive line is passed on to the downstream neighbour. The relay selector decides what drives the upstream transmit line: the station's own transmitter, or the line coming back from the downstream neighbour.

After reset no station forwards anything, so only the first unaddressed station hears the host. The host sends an assign command. The station that hears it stores the address and acknowledges through its own transmitter. Once that acknowledge has fully left the transmitter, the station opens both paths, and the next assign command reaches the next station in line. When an assign command gets no acknowledge, the host knows how long the chain is. After enumeration, data commands pass every station. Each station hands to its application only the payload whose address byte equals its own address. A one-byte broadcast reset returns every station to the unaddressed state.

The byte UART and the application itself are outside this block. They connect through a valid/ready byte stream for transmit, a valid strobe for received bytes and a one-cycle payload strobe for the application.

Top module: `chain_node`

## Requirements
- R1: After reset, addr_valid, node_addr, fwd_down, up_relay and otx_valid are all 0, ds_tx_line is at the idle level (1) and us_tx_line follows own_tx_line.
- R2: When the node is unaddressed and receives the two-byte assign command (opcode 0xA5, then address n), it sets node_addr to n and addr_valid to 1. It then offers on the otx stream the acknowledge opcode 0x6B, followed by n.
- R3: fwd_down and up_relay stay 0 while the acknowledge is being sent. Both become 1 on the clock edge after the first cycle in which otx_idle is high after the second acknowledge byte was accepted. otx_idle must fall no later than the cycle after an accepted byte.
- R4: A node with addr_valid = 1 that receives an assign command keeps node_addr unchanged and offers no byte on the otx stream.
- R5: us_tx_line equals ds_rx_line when up_relay is 1 and own_tx_line otherwise. ds_tx_line equals us_rx_line when fwd_down is 1 and is held at 1 otherwise.
- R6: A data command (opcode 0xD1, address byte, payload byte) raises app_valid for exactly one cycle with app_data equal to the payload. This happens in the cycle after the payload byte is received, and only if addr_valid is 1 and the address byte equals node_addr.
- R7: The broadcast reset byte 0xF0, received between commands, clears addr_valid and node_addr and returns fwd_down and up_relay to 0. An acknowledge in progress is abandoned and never opens the paths.
- R8: A byte that occupies the address or payload slot of a command is never decoded as an opcode. For example, assign with address 0xF0 gives node_addr = 0xF0 and does not reset the node.
- R9: An unaddressed node never raises app_valid, whatever data command it receives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | A received upstream byte is present this cycle |
| rx_data | input | BYTE_W | Received upstream byte |
| otx_valid | output | 1 | Byte offered to the node's own transmitter |
| otx_data | output | BYTE_W | Byte offered to the transmitter |
| otx_ready | input | 1 | Transmitter accepts the offered byte this cycle |
| otx_idle | input | 1 | Transmitter has finished shifting out every accepted byte |
| app_valid | output | 1 | One-cycle strobe: a payload addressed to this node |
| app_data | output | BYTE_W | Payload for the application |
| node_addr | output | BYTE_W | Address held by the node |
| addr_valid | output | 1 | The node holds an address |
| fwd_down | output | 1 | Forward selector: upstream receive passed downstream |
| up_relay | output | 1 | Relay selector: downstream line drives upstream transmit |
| us_rx_line | input | LINE_W | Serial line arriving from upstream |
| ds_rx_line | input | LINE_W | Serial line arriving from downstream |
| own_tx_line | input | LINE_W | Serial output of the node's own transmitter |
| ds_tx_line | output | LINE_W | Serial line toward downstream |
| us_tx_line | output | LINE_W | Serial line toward upstream |

## Verification
The embedded properties check several rules on every cycle. Forwarding never happens without an address. The relay selector only rises after the transmitter reported idle, and the node's own stream is silent while it relays. A held address never changes. A stalled transmit byte stays stable, payload strobes appear only for an addressed node, and the decoder never produces two events in one cycle. The byte order of the acknowledge, the exact cycle in which the paths open, address matching and mismatching, opcode values inside operand slots, and a reset that arrives in the middle of an acknowledge can only be shown by the bench scenarios.

// File: rtl/chain_node_pkg.sv
package chain_node_pkg;
   typedef enum logic [1:0] {
      DEC_IDLE,
      DEC_ASGN,
      DEC_DADR,
      DEC_DPAY
   } dec_state_t;

   typedef enum logic [1:0] {
      ACK_IDLE,
      ACK_OPC,
      ACK_ADR,
      ACK_DRAIN
   } ack_state_t;
endpackage

// File: rtl/chain_cmd_dec.sv
module chain_cmd_dec
   import chain_node_pkg::*;
#(
   parameter int unsigned BYTE_W = 8,
   parameter logic [BYTE_W-1:0] OP_ASSIGN = 8'hA5,
   parameter logic [BYTE_W-1:0] OP_DATA = 8'hD1,
   parameter logic [BYTE_W-1:0] OP_RESET = 8'hF0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_data,
   input  logic [BYTE_W-1:0] my_addr,
   input  logic              have_addr,
   output logic              assign_hit,
   output logic [BYTE_W-1:0] assign_addr,
   output logic              reset_hit,
   output logic              app_valid,
   output logic [BYTE_W-1:0] app_data
);
   dec_state_t state;
   logic       match_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= DEC_IDLE;
         match_q     <= 1'b0;
         assign_hit  <= 1'b0;
         assign_addr <= '0;
         reset_hit   <= 1'b0;
         app_valid   <= 1'b0;
         app_data    <= '0;
      end else begin
         assign_hit <= 1'b0;
         reset_hit  <= 1'b0;
         app_valid  <= 1'b0;
         if (rx_valid) begin
            unique case (state)
               DEC_IDLE: begin
                  if (rx_data == OP_ASSIGN)     state <= DEC_ASGN;
                  else if (rx_data == OP_DATA)  state <= DEC_DADR;
                  else if (rx_data == OP_RESET) reset_hit <= 1'b1;
               end
               DEC_ASGN: begin
                  assign_hit  <= 1'b1;
                  assign_addr <= rx_data;
                  state       <= DEC_IDLE;
               end
               DEC_DADR: begin
                  match_q <= have_addr && (rx_data == my_addr);
                  state   <= DEC_DPAY;
               end
               DEC_DPAY: begin
                  if (match_q) begin
                     app_valid <= 1'b1;
                     app_data  <= rx_data;
                  end
                  state <= DEC_IDLE;
               end
               default: state <= DEC_IDLE;
            endcase
         end
      end
   end

   // R6
   app_needs_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      app_valid |-> have_addr);

   // R8
   single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({assign_hit, reset_hit, app_valid}));
endmodule

// File: rtl/chain_ack_seq.sv
module chain_ack_seq
   import chain_node_pkg::*;
#(
   parameter int unsigned BYTE_W = 8,
   parameter logic [BYTE_W-1:0] OP_ACK = 8'h6B
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [BYTE_W-1:0] start_addr,
   input  logic              abort,
   input  logic              otx_ready,
   input  logic              otx_idle,
   output logic              otx_valid,
   output logic [BYTE_W-1:0] otx_data,
   output logic              done
);
   ack_state_t        state;
   logic [BYTE_W-1:0] echo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ACK_IDLE;
         echo_q <= '0;
      end else if (abort) begin
         state <= ACK_IDLE;
      end else begin
         unique case (state)
            ACK_IDLE:  if (start) begin
                          echo_q <= start_addr;
                          state  <= ACK_OPC;
                       end
            ACK_OPC:   if (otx_ready) state <= ACK_ADR;
            ACK_ADR:   if (otx_ready) state <= ACK_DRAIN;
            ACK_DRAIN: if (otx_idle)  state <= ACK_IDLE;
            default:   state <= ACK_IDLE;
         endcase
      end
   end

   always_comb begin
      otx_valid = (state == ACK_OPC) || (state == ACK_ADR);
      otx_data  = (state == ACK_ADR) ? echo_q : OP_ACK;
      done      = (state == ACK_DRAIN) && otx_idle && !abort;
   end

   // R2
   hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n || abort)
      (otx_valid && !otx_ready) |=> (otx_valid && $stable(otx_data)));
endmodule

// File: rtl/chain_path_sel.sv
module chain_path_sel #(
   parameter int unsigned LINE_W = 1,
   parameter bit IDLE_LEVEL = 1'b1
) (
   input  logic              fwd_down,
   input  logic              up_relay,
   input  logic [LINE_W-1:0] us_rx_line,
   input  logic [LINE_W-1:0] ds_rx_line,
   input  logic [LINE_W-1:0] own_tx_line,
   output logic [LINE_W-1:0] ds_tx_line,
   output logic [LINE_W-1:0] us_tx_line
);
   for (genvar g = 0; g < LINE_W; g++) begin : g_lane
      assign ds_tx_line[g] = fwd_down ? us_rx_line[g] : IDLE_LEVEL;
      assign us_tx_line[g] = up_relay ? ds_rx_line[g] : own_tx_line[g];
   end
endmodule

// File: rtl/chain_node.sv
module chain_node #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned LINE_W = 1,
   parameter bit IDLE_LEVEL = 1'b1,
   parameter logic [BYTE_W-1:0] OP_ASSIGN = 8'hA5,
   parameter logic [BYTE_W-1:0] OP_ACK = 8'h6B,
   parameter logic [BYTE_W-1:0] OP_DATA = 8'hD1,
   parameter logic [BYTE_W-1:0] OP_RESET = 8'hF0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_data,
   output logic              otx_valid,
   output logic [BYTE_W-1:0] otx_data,
   input  logic              otx_ready,
   input  logic              otx_idle,
   output logic              app_valid,
   output logic [BYTE_W-1:0] app_data,
   output logic [BYTE_W-1:0] node_addr,
   output logic              addr_valid,
   output logic              fwd_down,
   output logic              up_relay,
   input  logic [LINE_W-1:0] us_rx_line,
   input  logic [LINE_W-1:0] ds_rx_line,
   input  logic [LINE_W-1:0] own_tx_line,
   output logic [LINE_W-1:0] ds_tx_line,
   output logic [LINE_W-1:0] us_tx_line
);
   localparam int unsigned N_OPS = 3;

   initial begin : param_chk
      assert (BYTE_W >= 2) else $error("BYTE_W too small");
      assert (LINE_W >= 1) else $error("LINE_W must be at least 1");
      assert (OP_ASSIGN != OP_DATA && OP_ASSIGN != OP_RESET && OP_DATA != OP_RESET)
         else $error("the %0d received opcodes must differ", N_OPS);
   end

   logic              assign_hit, reset_hit, ack_start, ack_done;
   logic [BYTE_W-1:0] assign_addr;

   chain_cmd_dec #(.BYTE_W(BYTE_W), .OP_ASSIGN(OP_ASSIGN), .OP_DATA(OP_DATA),
                   .OP_RESET(OP_RESET)) i_dec (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .my_addr(node_addr), .have_addr(addr_valid),
      .assign_hit(assign_hit), .assign_addr(assign_addr), .reset_hit(reset_hit),
      .app_valid(app_valid), .app_data(app_data));

   assign ack_start = assign_hit && !addr_valid;

   chain_ack_seq #(.BYTE_W(BYTE_W), .OP_ACK(OP_ACK)) i_ack (
      .clk(clk), .rst_n(rst_n), .start(ack_start), .start_addr(assign_addr),
      .abort(reset_hit), .otx_ready(otx_ready), .otx_idle(otx_idle),
      .otx_valid(otx_valid), .otx_data(otx_data), .done(ack_done));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         node_addr  <= '0;
         addr_valid <= 1'b0;
         fwd_down   <= 1'b0;
         up_relay   <= 1'b0;
      end else if (reset_hit) begin
         node_addr  <= '0;
         addr_valid <= 1'b0;
         fwd_down   <= 1'b0;
         up_relay   <= 1'b0;
      end else begin
         if (ack_start) begin
            node_addr  <= assign_addr;
            addr_valid <= 1'b1;
         end
         if (ack_done) begin
            fwd_down <= 1'b1;
            up_relay <= 1'b1;
         end
      end
   end

   chain_path_sel #(.LINE_W(LINE_W), .IDLE_LEVEL(IDLE_LEVEL)) i_path (
      .fwd_down(fwd_down), .up_relay(up_relay), .us_rx_line(us_rx_line),
      .ds_rx_line(ds_rx_line), .own_tx_line(own_tx_line),
      .ds_tx_line(ds_tx_line), .us_tx_line(us_tx_line));

   // R3
   fwd_needs_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_down |-> addr_valid);

   // R3
   relay_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(up_relay) |-> $past(otx_idle));

   // R3
   silent_in_relay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up_relay |-> !otx_valid);

   // R4
   addr_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_valid && $past(addr_valid)) |-> $stable(node_addr));
endmodule

// File: tb/test_chain_node.sv
module test_chain_node;
   localparam int TXLEN = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = '0;
   logic       otx_valid, otx_ready, otx_idle;
   logic [7:0] otx_data;
   logic       app_valid;
   logic [7:0] app_data, node_addr;
   logic       addr_valid, fwd_down, up_relay;
   logic       us_rx_line = 1'b0, ds_rx_line = 1'b0, own_tx_line = 1'b0;
   logic       ds_tx_line, us_tx_line;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   int         busy = 0;
   int         tx_cnt = 0;
   logic [7:0] tx_b [16];

   always #5 clk = ~clk;

   chain_node i_chain_node (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .otx_valid(otx_valid), .otx_data(otx_data), .otx_ready(otx_ready),
      .otx_idle(otx_idle), .app_valid(app_valid), .app_data(app_data),
      .node_addr(node_addr), .addr_valid(addr_valid), .fwd_down(fwd_down),
      .up_relay(up_relay), .us_rx_line(us_rx_line), .ds_rx_line(ds_rx_line),
      .own_tx_line(own_tx_line), .ds_tx_line(ds_tx_line), .us_tx_line(us_tx_line));

   assign otx_ready = (busy == 0);
   assign otx_idle  = (busy == 0);

   always @(posedge clk) begin
      if (otx_valid && otx_ready) begin
         tx_b[tx_cnt % 16] <= otx_data;
         tx_cnt <= tx_cnt + 1;
         busy   <= TXLEN;
      end else if (busy != 0) begin
         busy <= busy - 1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic send_byte(input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = b;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic idle_cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset_state;
      @(negedge clk);
      chk(addr_valid == 0 && node_addr == 0, "R1", "address after reset", node_addr, 0);
      chk(fwd_down == 0 && up_relay == 0, "R1", "selectors after reset",
          {fwd_down, up_relay}, 0);
      chk(otx_valid == 0, "R1", "otx_valid after reset", otx_valid, 0);
      chk(ds_tx_line == 1, "R1", "ds_tx_line idle", ds_tx_line, 1);
      own_tx_line = 1'b1; #1;
      chk(us_tx_line == 1, "R1", "us_tx_line own", us_tx_line, 1);
      own_tx_line = 1'b0;
   endtask

   task automatic t_unaddressed_data;
      bit seen = 0;
      send_byte(8'hD1); send_byte(8'h00); send_byte(8'h55);
      seen = app_valid;
      idle_cycles(2);
      seen = seen | app_valid;
      chk(!seen, "R9", "app_valid while unaddressed", seen, 0);
   endtask

   task automatic t_paths(input bit relay_exp);
      for (int v = 0; v < 4; v++) begin
         us_rx_line  = v[0];
         ds_rx_line  = v[1];
         own_tx_line = ~v[0];
         #1;
         chk(us_tx_line == (relay_exp ? v[1] : ~v[0]), "R5", "us_tx_line",
             us_tx_line, relay_exp ? v[1] : ~v[0]);
         chk(ds_tx_line == (relay_exp ? v[0] : 1'b1), "R5", "ds_tx_line",
             ds_tx_line, relay_exp ? v[0] : 1'b1);
      end
      us_rx_line = 0; ds_rx_line = 0; own_tx_line = 0;
   endtask

   task automatic t_assign(input logic [7:0] a);
      int base = tx_cnt;
      int idle_at = -1;
      int relay_at = -1;
      bit early = 0;
      send_byte(8'hA5);
      send_byte(a);
      @(negedge clk);
      chk(addr_valid == 1 && node_addr == a, "R2", "stored address", node_addr, a);
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (up_relay) begin relay_at = i; break; end
         if (fwd_down) early = 1;
         if (idle_at < 0 && tx_cnt == base + 2 && otx_idle) idle_at = i;
      end
      chk(tx_cnt == base + 2, "R2", "acknowledge byte count", tx_cnt - base, 2);
      chk(tx_b[base % 16] == 8'h6B, "R2", "acknowledge opcode", tx_b[base % 16], 8'h6B);
      chk(tx_b[(base + 1) % 16] == a, "R2", "acknowledge echo", tx_b[(base + 1) % 16], a);
      chk(!early, "R3", "forward opened before relay", early, 0);
      chk(idle_at >= 0 && relay_at == idle_at + 1, "R3", "relay opening cycle",
          relay_at, idle_at + 1);
      chk(fwd_down == 1, "R3", "forward opened", fwd_down, 1);
   endtask

   task automatic t_data;
      send_byte(8'hD1); send_byte(node_addr); send_byte(8'h3C);
      chk(app_valid == 1 && app_data == 8'h3C, "R6", "matching payload", app_data, 8'h3C);
      @(negedge clk);
      chk(app_valid == 0, "R6", "strobe one cycle", app_valid, 0);
      send_byte(8'hD1); send_byte(node_addr + 8'd1); send_byte(8'h77);
      chk(app_valid == 0, "R6", "mismatching address", app_valid, 0);
      send_byte(8'hD1); send_byte(node_addr); send_byte(8'hA5);
      chk(app_valid == 1 && app_data == 8'hA5, "R8", "opcode value as payload",
          app_data, 8'hA5);
   endtask

   task automatic t_reassign(input logic [7:0] held);
      int base = tx_cnt;
      bit offered = 0;
      send_byte(8'hA5); send_byte(8'h09);
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (otx_valid) offered = 1;
      end
      chk(node_addr == held && addr_valid == 1, "R4", "address unchanged", node_addr, held);
      chk(!offered && tx_cnt == base, "R4", "no acknowledge", tx_cnt - base, 0);
   endtask

   task automatic t_reset_cmd;
      send_byte(8'hF0);
      @(negedge clk);
      chk(addr_valid == 0 && node_addr == 0, "R7", "address cleared", node_addr, 0);
      chk(fwd_down == 0 && up_relay == 0, "R7", "selectors cleared", {fwd_down, up_relay}, 0);
      us_rx_line = 1'b0; #1;
      chk(ds_tx_line == 1, "R7", "ds_tx_line back to idle", ds_tx_line, 1);
   endtask

   task automatic t_reset_mid_ack;
      bit opened = 0;
      send_byte(8'hA5); send_byte(8'h21);
      idle_cycles(2);
      send_byte(8'hF0);
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (fwd_down || up_relay) opened = 1;
      end
      chk(!opened, "R7", "aborted acknowledge opened paths", opened, 0);
      chk(addr_valid == 0 && otx_valid == 0, "R7", "state after abort",
          {addr_valid, otx_valid}, 0);
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      chk(0, "WD", "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      idle_cycles(3);
      rst_n = 1'b1;
      t_reset_state();
      t_unaddressed_data();
      t_paths(1'b0);
      t_assign(8'h03);
      t_paths(1'b1);
      t_data();
      t_reassign(8'h03);
      t_reset_cmd();
      t_assign(8'hF0);
      chk(addr_valid == 1 && node_addr == 8'hF0, "R8", "opcode value as address",
          node_addr, 8'hF0);
      t_data();
      t_reset_cmd();
      t_reset_mid_ack();
      idle_cycles(20);
      t_assign(8'h44);
      finish_run();
   end
endmodule